// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in in one combinational pass. The operand width is split into equal slices. Each slice forms per-bit propagate (the XOR of the two operand bits) and per-bit generate (their AND). From these and its own carry-in, each slice derives every internal carry in two-level form. Each slice also reports a group propagate and a group generate. A second-level lookahead network applies the same carry equations to the slice group signals and the adder carry-in. It produces the carry-in of every slice and the final carry-out, so no carry ripples from slice to slice.

A build-time parameter can connect the slices as a ripple chain instead, for area comparison. Both connections must give identical results. The group propagate and generate of the whole word are output ports, so a wider adder can place this block beneath a further lookahead level. There is no clock, no state and no handshake: the outputs follow the inputs in the same cycle. Flow control and staging are left to whatever surrounds the block.

Top module: `cla_adder_2l`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^WIDTH, for every input combination.
- R2: `carry_out` equals bit WIDTH of the (WIDTH+1)-bit value `op_a` + `op_b` + `carry_in`.
- R3: `group_prop` is 1 exactly when `op_a` XOR `op_b` is all ones.
- R4: `group_gen` is 1 exactly when `op_a` + `op_b` alone (carry-in taken as 0) exceeds 2^WIDTH − 1.
- R5: `group_prop` and `group_gen` are never both 1. When `group_prop` is 1, `carry_out` equals `carry_in`. When `group_gen` is 1, `carry_out` is 1.
- R6: The lookahead connection (MODE = CARRY_LOOKAHEAD) and the ripple connection (MODE = CARRY_RIPPLE) give the same `sum`, `carry_out`, `group_prop` and `group_gen` for every input.
- R7: The carry into slice k equals bit k·SLICE_W of the sum of the low k·SLICE_W bits of both operands plus `carry_in`. It is produced within the same evaluation as the inputs, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the result |
| carry_out | output | 1 | Carry out of the top bit |
| group_prop | output | 1 | Whole-word propagate |
| group_gen | output | 1 | Whole-word generate |

## Verification
The bench builds two copies with WIDTH = 8 and SLICE_W = 4, one using the lookahead connection and one using the ripple connection. It sweeps all 2^17 operand and carry-in combinations through both. At this size every carry pattern across the slice boundary is reached, including full propagation through both slices, and each result is compared against arithmetic and across the two modes. A third copy uses the default 16-bit, four-slice build. It is driven with corner values (all-propagate words, all-generate words, single set bits) and with patterns derived from the sweep, so that carries run through all four slices and the full second-level network.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic {
    CARRY_RIPPLE    = 1'b0,
    CARRY_LOOKAHEAD = 1'b1
  } carry_mode_e;
endpackage

// File: rtl/cla_carry_net.sv
// Two-level carry expansion: every carry is a sum of products of p, g and cin.
module cla_carry_net #(
  parameter int N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N:0]   c,
  output logic         gp,
  output logic         gg
);
  always_comb begin
    logic term;
    c    = '0;
    c[0] = cin;
    for (int i = 1; i <= N; i++) begin
      term = cin;
      for (int k = 0; k < i; k++) term = term & p[k];
      c[i] = term;
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        c[i] = c[i] | term;
      end
    end
  end

  always_comb begin
    logic t2;
    gp = &p;
    gg = 1'b0;
    for (int j = 0; j < N; j++) begin
      t2 = g[j];
      for (int k = j + 1; k < N; k++) t2 = t2 & p[k];
      gg = gg | t2;
    end
  end

  // The expanded top carry must agree with the group form gg + gp*cin.
  always_comb begin
    if (!$isunknown({p, g, cin})) begin
      assert_group_carry_R5: assert (c[N] == (gg | (gp & cin)))
        else $error("group carry form disagrees with expanded carry");
    end
  end
endmodule

// File: rtl/cla_slice.sv
// One lookahead slice: bit propagate/generate, internal carries, sum, group signals.
module cla_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         gp,
  output logic         gg
);
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_g;
  logic [W:0]   carries;

  assign bit_p = a ^ b;
  assign bit_g = a & b;

  cla_carry_net #(.N(W)) u_net (
    .p   (bit_p),
    .g   (bit_g),
    .cin (cin),
    .c   (carries),
    .gp  (gp),
    .gg  (gg)
  );

  assign sum  = bit_p ^ carries[W-1:0];
  assign cout = carries[W];

  always_comb begin
    logic [W:0] chk_total;
    chk_total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    if (!$isunknown({a, b, cin})) begin
      assert_slice_sum_R1: assert ({cout, sum} == chk_total)
        else $error("slice result differs from arithmetic sum");
    end
  end
endmodule

// File: rtl/cla_adder_2l.sv
module cla_adder_2l #(
  parameter int                  WIDTH   = 16,
  parameter int                  SLICE_W = 4,
  parameter cla_pkg::carry_mode_e MODE   = cla_pkg::CARRY_LOOKAHEAD
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             group_prop,
  output logic             group_gen
);
  localparam int NG = WIDTH / SLICE_W;

  logic [NG-1:0] grp_p;
  logic [NG-1:0] grp_g;
  logic [NG-1:0] slice_cout;
  logic [NG:0]   slice_cin;
  logic [NG:0]   la_carry;

  for (genvar k = 0; k < NG; k++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a    (op_a[k*SLICE_W +: SLICE_W]),
      .b    (op_b[k*SLICE_W +: SLICE_W]),
      .cin  (slice_cin[k]),
      .sum  (sum[k*SLICE_W +: SLICE_W]),
      .cout (slice_cout[k]),
      .gp   (grp_p[k]),
      .gg   (grp_g[k])
    );
  end

  // Second-level lookahead over the slice group signals.
  cla_carry_net #(.N(NG)) u_level2 (
    .p   (grp_p),
    .g   (grp_g),
    .cin (carry_in),
    .c   (la_carry),
    .gp  (group_prop),
    .gg  (group_gen)
  );

  if (MODE == cla_pkg::CARRY_LOOKAHEAD) begin : g_lookahead
    assign slice_cin = la_carry;
  end else begin : g_ripple
    assign slice_cin[0] = carry_in;
    for (genvar k = 0; k < NG; k++) begin : g_link
      assign slice_cin[k+1] = slice_cout[k];
    end
  end

  assign carry_out = slice_cin[NG];

  always_comb begin
    logic [WIDTH:0] chk_total;
    logic [WIDTH:0] chk_nocin;
    logic [WIDTH:0] chk_low;
    logic [WIDTH-1:0] low_mask;
    chk_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    chk_nocin = {1'b0, op_a} + {1'b0, op_b};
    if (!$isunknown({op_a, op_b, carry_in})) begin
      assert_word_sum_R1: assert (sum == chk_total[WIDTH-1:0])
        else $error("sum differs from arithmetic");
      assert_word_carry_R2: assert (carry_out == chk_total[WIDTH])
        else $error("carry_out differs from arithmetic");
      assert_group_prop_R3: assert (group_prop == ((op_a ^ op_b) == '1))
        else $error("group_prop wrong");
      assert_group_gen_R4: assert (group_gen == chk_nocin[WIDTH])
        else $error("group_gen wrong");
      assert_pg_exclusive_R5: assert (!(group_prop && group_gen))
        else $error("group propagate and generate both set");
      assert_prop_pass_R5: assert (!group_prop || (carry_out == carry_in))
        else $error("propagating word did not pass carry_in");
      assert_modes_agree_R6: assert (la_carry == slice_cin)
        else $error("slice carry-ins differ from second-level carries");
      for (int k = 0; k < NG; k++) begin
        assert_link_R7: assert (slice_cout[k] == slice_cin[k+1])
          else $error("slice carry-out does not match next carry-in");
        low_mask = (WIDTH'(1) << (k * SLICE_W)) - WIDTH'(1);
        chk_low  = {1'b0, op_a & low_mask} + {1'b0, op_b & low_mask}
                 + {{WIDTH{1'b0}}, carry_in};
        assert_slice_cin_R7: assert (slice_cin[k] == chk_low[k*SLICE_W])
          else $error("slice carry-in differs from low-part carry");
      end
    end
  end
endmodule

// File: tb/test_cla_adder_2l.sv
module test_cla_adder_2l;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Small build, two connection modes
  logic [7:0] sa, sb;
  logic       scin;
  logic [7:0] s_sum_la, s_sum_rp;
  logic       s_co_la, s_co_rp, s_gp_la, s_gp_rp, s_gg_la, s_gg_rp;

  // Default build
  logic [15:0] la, lb;
  logic        lcin;
  logic [15:0] l_sum;
  logic        l_co, l_gp, l_gg;

  cla_adder_2l #(.WIDTH(8), .SLICE_W(4), .MODE(cla_pkg::CARRY_LOOKAHEAD)) i_cla_adder_2l (
    .op_a(sa), .op_b(sb), .carry_in(scin), .sum(s_sum_la),
    .carry_out(s_co_la), .group_prop(s_gp_la), .group_gen(s_gg_la));

  cla_adder_2l #(.WIDTH(8), .SLICE_W(4), .MODE(cla_pkg::CARRY_RIPPLE)) i_cla_adder_2l_ripple (
    .op_a(sa), .op_b(sb), .carry_in(scin), .sum(s_sum_rp),
    .carry_out(s_co_rp), .group_prop(s_gp_rp), .group_gen(s_gg_rp));

  cla_adder_2l i_cla_adder_2l_wide (
    .op_a(la), .op_b(lb), .carry_in(lcin), .sum(l_sum),
    .carry_out(l_co), .group_prop(l_gp), .group_gen(l_gg));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_small();
    logic [8:0] tot, nc;
    tot = {1'b0, sa} + {1'b0, sb} + 9'(scin);
    nc  = {1'b0, sa} + {1'b0, sb};
    n_vec++;
    check(s_sum_la == tot[7:0], "R1/R7 small sum", 32'(s_sum_la), 32'(tot[7:0]));
    check(s_co_la == tot[8], "R2 small carry", 32'(s_co_la), 32'(tot[8]));
    check(s_gp_la == ((sa ^ sb) == 8'hff), "R3 small gp", 32'(s_gp_la), 32'((sa ^ sb) == 8'hff));
    check(s_gg_la == nc[8], "R4 small gg", 32'(s_gg_la), 32'(nc[8]));
    check(!(s_gp_la && s_gg_la), "R5 small exclusive", 32'({s_gp_la, s_gg_la}), 32'h0);
    check({s_sum_rp, s_co_rp, s_gp_rp, s_gg_rp} == {s_sum_la, s_co_la, s_gp_la, s_gg_la},
          "R6 modes", 32'({s_sum_rp, s_co_rp, s_gp_rp, s_gg_rp}),
          32'({s_sum_la, s_co_la, s_gp_la, s_gg_la}));
  endtask

  task automatic check_wide();
    logic [16:0] tot, nc;
    tot = {1'b0, la} + {1'b0, lb} + 17'(lcin);
    nc  = {1'b0, la} + {1'b0, lb};
    n_vec++;
    check(l_sum == tot[15:0], "R1/R7 wide sum", 32'(l_sum), 32'(tot[15:0]));
    check(l_co == tot[16], "R2 wide carry", 32'(l_co), 32'(tot[16]));
    check(l_gp == ((la ^ lb) == 16'hffff), "R3 wide gp", 32'(l_gp), 32'((la ^ lb) == 16'hffff));
    check(l_gg == nc[16], "R4 wide gg", 32'(l_gg), 32'(nc[16]));
    check(!l_gp || (l_co == lcin), "R5 wide pass-through", 32'(l_co), 32'(lcin));
  endtask

  task automatic apply_wide(input logic [15:0] a, input logic [15:0] b, input logic c);
    @(negedge clk);
    la = a; lb = b; lcin = c;
    #1 check_wide();
  endtask

  initial begin
    sa = '0; sb = '0; scin = 1'b0;
    la = '0; lb = '0; lcin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: zero inputs give zero outputs (R1, R2, R3, R4)
    @(negedge clk);
    #1 check_small();
    check_wide();
    // Wide corners
    apply_wide(16'hffff, 16'h0000, 1'b1);
    apply_wide(16'hffff, 16'h0000, 1'b0);
    apply_wide(16'h5555, 16'haaaa, 1'b1);
    apply_wide(16'haaaa, 16'h5555, 1'b0);
    apply_wide(16'hffff, 16'hffff, 1'b1);
    apply_wide(16'h8000, 16'h8000, 1'b0);
    apply_wide(16'h0fff, 16'h0001, 1'b0);
    apply_wide(16'h7fff, 16'h0000, 1'b1);
    for (int i = 0; i < 16; i++) begin
      apply_wide(16'(1) << i, 16'hffff, 1'b0);
      apply_wide(~(16'(1) << i), 16'(1) << i, 1'b1);
    end
    // Exhaustive small sweep, wide build driven in parallel
    for (int v = 0; v < (1 << 17); v++) begin
      @(negedge clk);
      {sa, sb, scin} = 17'(v);
      la   = {sa, ~sb};
      lb   = {sb ^ 8'h0f, sa};
      lcin = scin;
      #1;
      check_small();
      check_wide();
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule